// File: doc/BRIEF.md
# Page-to-Slot Memory Mapper

This block divides a 64 KB processor address space into four 16 KB pages and decides, for each memory cycle, which of four slots answers it. A small map register holds one 2-bit slot number per page. Software loads the register through a parallel-port write strobe and can read it back. The mapper takes the two top address bits, finds the slot number stored for that page, and drives the matching active-low slot-select line for as long as the memory cycle lasts.

Because a page reaches exactly one slot at a time, several slots can hold memory at the same addresses without ever driving the data bus together. A single 64 KB space can therefore be pieced together from ROM in one slot and RAM in another. After reset every page points at slot 0, so the start-up ROM in the low half of the space is reachable at once. The select path is combinational from the bus strobes. Only the map register is clocked.

Top module: `page_slot_mapper`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the map register to 00H, so `map_rdata` reads 00H and every page selects slot 0.
- R2: A clock edge with `map_we` high loads `map_wdata` into the map register. `map_rdata` shows the stored value from that edge onward and keeps it on edges with `map_we` low.
- R3: Page p is `page_addr` = p, where `page_addr` is address bits 15:14. Its slot number is map bits [2p+1:2p]. During a request, slot s drives `slot_sel_n[s]` low.
- R4: A select goes low only when `mreq_n` is low and `rd_n` or `wr_n` is low. Select lines are driven the same way for read cycles and write cycles. With `mreq_n` high, or with both `rd_n` and `wr_n` high, `slot_sel_n` is 4'b1111.
- R5: While `rfsh_n` is low (a refresh cycle), `slot_sel_n` is 4'b1111, even if a memory strobe is active.
- R6: At most one bit of `slot_sel_n` is low at any time.
- R7: With the map at E4H, pages 0, 1, 2 and 3 select slots 0, 1, 2 and 3 respectively.
- R8: `slot_sel_n` follows `page_addr` and the strobes within the same cycle, with no clock latency.
- R9: A map write made during an active memory cycle leaves the select unchanged until the loading clock edge. The new mapping applies right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map register |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_addr | input | 2 | Address bits 15:14 of the current cycle |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh cycle indicator, active low |
| map_we | input | 1 | Map register write strobe |
| map_wdata | input | 8 | Map register write data |
| map_rdata | output | 8 | Map register readback |
| slot_sel_n | output | 4 | Slot selects, active low, one per slot |

## Verification
Every page is paired with every slot number in turn while the other fields hold unlike values. This shows that each page decodes its own bit pair and not a neighbour's. The E4H identity map and the constant maps 00H and FFH tell a correct field order apart from reversed or fixed decodes. Strobe combinations run through read, write, idle, refresh and request-without-strobe, so gating faults appear as wrongly asserted or missing selects. A map write made during a live read shows whether the new mapping takes effect on the right edge.

// File: rtl/slotmap_pkg.sv
package slotmap_pkg;
   // bus strobes of one memory cycle, all active low
   typedef struct packed {
      logic mreq_n;
      logic rd_n;
      logic wr_n;
      logic rfsh_n;
   } bus_cyc_t;

   // width of the whole map register for a given page count and field width
   function automatic int map_width(input int pages, input int slot_w);
      return pages * slot_w;
   endfunction
endpackage

// File: rtl/slotmap_cfg_reg.sv
module slotmap_cfg_reg #(
   parameter int W         = 8,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("slotmap_cfg_reg: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/slotmap_page_mux.sv
module slotmap_page_mux #(
   parameter int PAGES  = 4,
   parameter int SLOT_W = 2,
   localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1,
   localparam int MAP_W = PAGES * SLOT_W
) (
   input  logic [MAP_W-1:0]  map,
   input  logic [PG_W-1:0]   page,
   output logic [SLOT_W-1:0] slot
);
   logic [SLOT_W-1:0] field [PAGES];

   generate
      if ((1 << PG_W) != PAGES) begin : g_bad_pages
         $error("slotmap_page_mux: PAGES must be a power of two");
      end
      for (genvar p = 0; p < PAGES; p++) begin : g_field
         assign field[p] = map[p*SLOT_W +: SLOT_W];
      end
   endgenerate

   assign slot = field[page];
endmodule

// File: rtl/slotmap_slot_dec.sv
module slotmap_slot_dec #(
   parameter int SLOT_W      = 2,
   parameter bit GATE_RFSH   = 1'b1,
   localparam int SLOTS      = 1 << SLOT_W
) (
   input  slotmap_pkg::bus_cyc_t cyc,
   input  logic [SLOT_W-1:0]     slot,
   output logic [SLOTS-1:0]      sel_n
);
   logic strobe;
   logic cycle_ok;

   assign strobe = !cyc.mreq_n && (!cyc.rd_n || !cyc.wr_n);

   generate
      if (GATE_RFSH) begin : g_rfsh_gate
         assign cycle_ok = strobe && cyc.rfsh_n;
      end else begin : g_no_rfsh_gate
         assign cycle_ok = strobe;
      end
      for (genvar s = 0; s < SLOTS; s++) begin : g_sel
         assign sel_n[s] = !(cycle_ok && (slot == SLOT_W'(s)));
      end
   endgenerate
endmodule

// File: rtl/page_slot_mapper.sv
module page_slot_mapper #(
   parameter int PAGES     = 4,
   parameter int SLOT_W    = 2,
   parameter bit GATE_RFSH = 1'b1,
   localparam int PG_W     = (PAGES > 1) ? $clog2(PAGES) : 1,
   localparam int MAP_W    = PAGES * SLOT_W,
   localparam int SLOTS    = 1 << SLOT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PG_W-1:0]  page_addr,
   input  logic             mreq_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic             rfsh_n,
   input  logic             map_we,
   input  logic [MAP_W-1:0] map_wdata,
   output logic [MAP_W-1:0] map_rdata,
   output logic [SLOTS-1:0] slot_sel_n
);
   import slotmap_pkg::*;

   generate
      if (MAP_W != map_width(PAGES, SLOT_W)) begin : g_bad_map
         $error("page_slot_mapper: map width mismatch");
      end
      if (PAGES < 2) begin : g_bad_pages
         $error("page_slot_mapper: at least two pages required");
      end
   endgenerate

   bus_cyc_t          cyc;
   logic [SLOT_W-1:0] cur_slot;

   assign cyc = '{mreq_n: mreq_n, rd_n: rd_n, wr_n: wr_n, rfsh_n: rfsh_n};

   // map register, cleared to slot 0 for every page (R1, R2)
   slotmap_cfg_reg #(.W(MAP_W), .RESET_VAL('0)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (map_we),
      .wdata (map_wdata),
      .q     (map_rdata)
   );

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      map_we |=> (map_rdata == $past(map_wdata)));
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !map_we |=> $stable(map_rdata));

   // per-page field selection (R3)
   slotmap_page_mux #(.PAGES(PAGES), .SLOT_W(SLOT_W)) u_mux (
      .map  (map_rdata),
      .page (page_addr),
      .slot (cur_slot)
   );

   // strobe-gated one-hot decode (R4, R5, R6)
   slotmap_slot_dec #(.SLOT_W(SLOT_W), .GATE_RFSH(GATE_RFSH)) u_dec (
      .cyc   (cyc),
      .slot  (cur_slot),
      .sel_n (slot_sel_n)
   );

   p_single_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~slot_sel_n));
   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_n || (rd_n && wr_n)) |-> (&slot_sel_n));
   p_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (GATE_RFSH && !rfsh_n) |-> (&slot_sel_n));
   p_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && !rd_n && rfsh_n) |-> ($countones(~slot_sel_n) == 1));
endmodule

// File: tb/page_slot_mapper_tb.sv
module page_slot_mapper_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] page_addr = 2'd0;
   logic       mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
   logic       map_we = 1'b0;
   logic [7:0] map_wdata = 8'h00;
   logic [7:0] map_rdata;
   logic [3:0] slot_sel_n;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   page_slot_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .page_addr(page_addr),
      .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n),
      .map_we(map_we), .map_wdata(map_wdata),
      .map_rdata(map_rdata), .slot_sel_n(slot_sel_n)
   );

   function automatic logic [3:0] exp_sel(input logic [7:0] m, input logic [1:0] pg,
                                         input logic act);
      logic [1:0] s;
      s = m[pg*2 +: 2];
      return act ? ~(4'b0001 << s) : 4'b1111;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic set_bus(input logic mq, input logic rd, input logic wr,
                          input logic rf, input logic [1:0] pg);
      mreq_n = mq; rd_n = rd; wr_n = wr; rfsh_n = rf; page_addr = pg;
      #2;
   endtask

   task automatic write_map(input logic [7:0] v);
      @(negedge clk);
      map_we = 1'b1; map_wdata = v;
      @(negedge clk);
      map_we = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 reset map", map_rdata, 8'h00);
      for (int p = 0; p < 4; p++) begin
         set_bus(1'b0, 1'b0, 1'b1, 1'b1, 2'(p));
         chk("R1 reset slot0", {4'h0, slot_sel_n}, {4'h0, 4'b1110});
      end
      set_bus(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
   endtask

   task automatic t_write_read;
      write_map(8'h5A);
      chk("R2 readback", map_rdata, 8'h5A);
      @(negedge clk); @(negedge clk);
      chk("R2 hold", map_rdata, 8'h5A);
      write_map(8'hC3);
      chk("R2 second write", map_rdata, 8'hC3);
   endtask

   task automatic t_fields;
      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 4; s++) begin
            logic [7:0] m;
            m = 8'h00;
            for (int q = 0; q < 4; q++) m[q*2 +: 2] = 2'(3 - q);
            m[p*2 +: 2] = 2'(s);
            write_map(m);
            set_bus(1'b0, 1'b0, 1'b1, 1'b1, 2'(p));
            chk("R3 field read", {4'h0, slot_sel_n}, {4'h0, exp_sel(m, 2'(p), 1'b1)});
            set_bus(1'b0, 1'b1, 1'b0, 1'b1, 2'(p));
            chk("R4 field write", {4'h0, slot_sel_n}, {4'h0, exp_sel(m, 2'(p), 1'b1)});
            set_bus(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
         end
      end
   endtask

   task automatic t_identity;
      write_map(8'hE4);
      for (int p = 0; p < 4; p++) begin
         set_bus(1'b0, 1'b0, 1'b1, 1'b1, 2'(p));
         chk("R7 identity", {4'h0, slot_sel_n}, {4'h0, ~(4'b0001 << p)});
         chk("R6 one select", 8'($countones(~slot_sel_n)), 8'd1);
      end
      set_bus(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
   endtask

   task automatic t_constant_maps;
      write_map(8'hFF);
      for (int p = 0; p < 4; p++) begin
         set_bus(1'b0, 1'b1, 1'b0, 1'b1, 2'(p));
         chk("R3 all slot3", {4'h0, slot_sel_n}, {4'h0, 4'b0111});
      end
      set_bus(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
   endtask

   task automatic t_gating;
      write_map(8'h1B);
      set_bus(1'b1, 1'b0, 1'b1, 1'b1, 2'd1);
      chk("R4 no mreq", {4'h0, slot_sel_n}, 8'h0F);
      set_bus(1'b0, 1'b1, 1'b1, 1'b1, 2'd1);
      chk("R4 mreq no strobe", {4'h0, slot_sel_n}, 8'h0F);
      set_bus(1'b0, 1'b1, 1'b1, 1'b0, 2'd2);
      chk("R5 refresh idle", {4'h0, slot_sel_n}, 8'h0F);
      set_bus(1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
      chk("R5 refresh with rd", {4'h0, slot_sel_n}, 8'h0F);
      set_bus(1'b0, 1'b0, 1'b1, 1'b1, 2'd2);
      chk("R4 after refresh", {4'h0, slot_sel_n}, {4'h0, exp_sel(8'h1B, 2'd2, 1'b1)});
      set_bus(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
   endtask

   task automatic t_comb_follow;
      write_map(8'h1B);
      @(negedge clk);
      set_bus(1'b0, 1'b0, 1'b1, 1'b1, 2'd0);
      chk("R8 page0", {4'h0, slot_sel_n}, {4'h0, 4'b0111});
      set_bus(1'b0, 1'b0, 1'b1, 1'b1, 2'd3);
      chk("R8 page3 same cycle", {4'h0, slot_sel_n}, {4'h0, 4'b1110});
      set_bus(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
   endtask

   task automatic t_write_mid_cycle;
      write_map(8'h00);
      set_bus(1'b0, 1'b0, 1'b1, 1'b1, 2'd2);
      map_we = 1'b1; map_wdata = 8'h20;
      #2;
      chk("R9 before edge", {4'h0, slot_sel_n}, {4'h0, 4'b1110});
      @(posedge clk); #2;
      map_we = 1'b0;
      chk("R9 after edge", {4'h0, slot_sel_n}, {4'h0, 4'b1011});
      set_bus(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_fields();
      t_identity();
      t_constant_maps();
      t_gating();
      t_comb_follow();
      t_write_mid_cycle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule